// File: doc/BRIEF.md
# Six-Instruction Multicycle Processor Core

This block is a small 16-bit stored-program processor. A control unit (program counter, instruction register and a state machine) steps each instruction through a fixed fetch, decode and execute sequence. A datapath (a sixteen-entry register file, an ALU with pass, add and subtract, a three-way write-back selector and a zero detector on one read port) carries out the work that the instruction asks for.

The instruction memory and the 256-word data memory sit outside the core. The core drives an address and a read strobe to the instruction memory. It drives an address with a read or write strobe to the data memory. Both memories return read data combinationally in the same cycle. The instruction set has six instructions: memory load, memory store, register add, register subtract, load of an 8-bit constant, and a relative jump taken when a register is zero. Every other opcode does nothing.

Top module: `mcp_core`

## Requirements
- R1: While `rst` is high, `imem_rd`, `dmem_rd` and `dmem_wr` are low. On the second falling clock edge after `rst` is released, the core shows its first fetch (`imem_rd` high) at address 0.
- R2: Fetches occur exactly three cycles apart: fetch, decode and execute. Opcodes that do nothing also take three cycles.
- R3: Load (opcode bits 15..12 = 0000, register ra in bits 11..8, address d in bits 7..0) asserts `dmem_rd` with `dmem_addr` = d in its execute cycle and writes the memory word into RF[ra].
- R4: Store (0001, same fields) asserts `dmem_wr` in its execute cycle with `dmem_addr` = d and `dmem_wdata` = RF[ra]. No other instruction writes memory, and `dmem_rd` and `dmem_wr` are never high together.
- R5: Add (0010, ra in 11..8, rb in 7..4, rc in 3..0) writes RF[rb] + RF[rc] modulo 2^16 into RF[ra].
- R6: Load-constant (0011, ra, constant in 7..0) writes the constant, zero-extended to 16 bits, into RF[ra].
- R7: Subtract (0100, same fields as add) writes RF[rb] - RF[rc] modulo 2^16 into RF[ra].
- R8: Jump-if-zero (0101, ra, offset in 7..0) with RF[ra] = 0 makes the next fetch address equal to the jump's own address plus the offset sign-extended from 8 bits. Backward jumps are therefore possible.
- R9: Jump-if-zero with RF[ra] nonzero leaves the program counter as fetch left it, so the next fetch is the following address.
- R10: Opcodes 0110 to 1111 change no register, touch no memory and fall through to the following address.
- R11: Every instruction other than a taken jump is followed by a fetch at its own address plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W (16) | Instruction memory address (the program counter) |
| imem_rd | output | 1 | Instruction read strobe, high in the fetch cycle |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 8 | Data memory address |
| dmem_rd | output | 1 | Data memory read strobe |
| dmem_wr | output | 1 | Data memory write strobe |
| dmem_wdata | output | DATA_W (16) | Data memory write data |
| dmem_rdata | input | DATA_W (16) | Data memory read data at `dmem_addr` |

## Verification
A bad program counter shows up at the next fetch, at most three cycles later, as a wrong `imem_addr`. A wrong sequencer state shows up as fetch strobes that are not spaced three cycles apart, or as memory strobes outside an execute cycle. A corrupted register stays hidden until a store or a jump uses it. The bench therefore checks every store's address and data against an instruction-level model, and it checks every fetch address, so that a bad register value appears within one instruction of being consumed. Directed programs cover the zero-extension, wraparound, no-op and backward-jump cases. Random programs mix all opcodes.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  localparam int INSTR_W = 16;
  localparam int REG_AW  = 4;
  localparam int FIELD_W = 8;

  localparam logic [3:0] OPC_LOAD  = 4'h0;
  localparam logic [3:0] OPC_STORE = 4'h1;
  localparam logic [3:0] OPC_ADD   = 4'h2;
  localparam logic [3:0] OPC_LDC   = 4'h3;
  localparam logic [3:0] OPC_SUB   = 4'h4;
  localparam logic [3:0] OPC_JZ    = 4'h5;

  typedef enum logic [3:0] {
    ST_INIT, ST_FETCH, ST_DECODE,
    ST_LOAD, ST_STORE, ST_ADD, ST_LDC, ST_SUB, ST_JZ, ST_NOP
  } state_t;

  typedef enum logic [1:0] {
    WS_ALU   = 2'b00,
    WS_MEM   = 2'b01,
    WS_CONST = 2'b10
  } wsel_t;

  typedef enum logic [1:0] {
    AL_PASS = 2'b00,
    AL_ADD  = 2'b01,
    AL_SUB  = 2'b10
  } alu_op_t;
endpackage

// File: rtl/mcp_alu.sv
module mcp_alu import mcp_pkg::*; #(
  parameter int W = 16
) (
  input  alu_op_t        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  always_comb begin
    case (op)
      AL_ADD:  y = a + b;
      AL_SUB:  y = a - b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/mcp_regfile.sv
module mcp_regfile #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] paddr,
  output logic [W-1:0]  pdata,
  input  logic [AW-1:0] qaddr,
  output logic [W-1:0]  qdata
);
  localparam int DEPTH = 1 << AW;

  // no reset so the array maps onto distributed RAM
  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign pdata = regs[paddr];
  assign qdata = regs[qaddr];
endmodule

// File: rtl/mcp_ctrl.sv
module mcp_ctrl import mcp_pkg::*; #(
  parameter int PC_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] imem_data,
  input  logic               rf_pzero,
  output logic               imem_rd,
  output logic [PC_W-1:0]    pc,
  output logic [FIELD_W-1:0] imm,
  output logic               d_rd,
  output logic               d_wr,
  output logic               rf_we,
  output logic [REG_AW-1:0]  rf_waddr,
  output logic [REG_AW-1:0]  rf_paddr,
  output logic [REG_AW-1:0]  rf_qaddr,
  output wsel_t              wsel,
  output alu_op_t            alu_op
);
  localparam int PAD = PC_W - FIELD_W;

  state_t               state, nxt;
  logic [INSTR_W-1:0]   ir;
  logic [3:0]           opc;
  logic [REG_AW-1:0]    fa, fb, fc;
  logic [PC_W-1:0]      off_ext, jmp_tgt;

  assign opc = ir[15:12];
  assign fa  = ir[11:8];
  assign fb  = ir[7:4];
  assign fc  = ir[3:0];
  assign imm = ir[FIELD_W-1:0];

  // fetch has already advanced pc by one, so the adder takes one back
  assign off_ext = {{PAD{ir[FIELD_W-1]}}, ir[FIELD_W-1:0]};
  assign jmp_tgt = pc + off_ext - PC_W'(1);

  always_comb begin
    case (state)
      ST_INIT:   nxt = ST_FETCH;
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (opc)
          OPC_LOAD:  nxt = ST_LOAD;
          OPC_STORE: nxt = ST_STORE;
          OPC_ADD:   nxt = ST_ADD;
          OPC_LDC:   nxt = ST_LDC;
          OPC_SUB:   nxt = ST_SUB;
          OPC_JZ:    nxt = ST_JZ;
          default:   nxt = ST_NOP;
        endcase
      end
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_INIT;
      pc    <= '0;
      ir    <= '0;
    end else begin
      state <= nxt;
      case (state)
        ST_INIT:  pc <= '0;
        ST_FETCH: begin
          ir <= imem_data;
          pc <= pc + PC_W'(1);
        end
        ST_JZ:    if (rf_pzero) pc <= jmp_tgt;
        default:  ;
      endcase
    end
  end

  always_comb begin
    imem_rd  = 1'b0;
    d_rd     = 1'b0;
    d_wr     = 1'b0;
    rf_we    = 1'b0;
    rf_waddr = fa;
    rf_paddr = fa;
    rf_qaddr = fc;
    wsel     = WS_ALU;
    alu_op   = AL_PASS;
    case (state)
      ST_FETCH: imem_rd = 1'b1;
      ST_LOAD: begin
        d_rd  = 1'b1;
        wsel  = WS_MEM;
        rf_we = 1'b1;
      end
      ST_STORE: d_wr = 1'b1;
      ST_ADD: begin
        rf_paddr = fb;
        alu_op   = AL_ADD;
        rf_we    = 1'b1;
      end
      ST_SUB: begin
        rf_paddr = fb;
        alu_op   = AL_SUB;
        rf_we    = 1'b1;
      end
      ST_LDC: begin
        wsel  = WS_CONST;
        rf_we = 1'b1;
      end
      default: ;
    endcase
  end

  // R1: the first fetch after init reads address zero
  a_r1_start_at_zero: assert property (@(posedge clk) disable iff (rst)
    (imem_rd && $past(state) == ST_INIT) |-> pc == '0);

  // R2: fetch strobes are three cycles apart
  a_r2_fetch_period: assert property (@(posedge clk) disable iff (rst)
    imem_rd |-> ##3 imem_rd);

  a_r2_no_early_fetch: assert property (@(posedge clk) disable iff (rst)
    imem_rd |=> !imem_rd ##1 !imem_rd);

  // R11: fetch advances the program counter by one
  a_r11_fetch_step: assert property (@(posedge clk) disable iff (rst)
    imem_rd |=> pc == $past(pc) + PC_W'(1));

  // R9: an untaken jump leaves the program counter alone
  a_r9_untaken_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_JZ && !rf_pzero) |=> $stable(pc));

  // R10: an unused opcode writes nothing and touches no memory
  a_r10_nop_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NOP) |-> (!rf_we && !d_rd && !d_wr));
endmodule

// File: rtl/mcp_core.sv
module mcp_core import mcp_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int PC_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imem_addr,
  output logic               imem_rd,
  input  logic [INSTR_W-1:0] imem_data,
  output logic [FIELD_W-1:0] dmem_addr,
  output logic               dmem_rd,
  output logic               dmem_wr,
  output logic [DATA_W-1:0]  dmem_wdata,
  input  logic [DATA_W-1:0]  dmem_rdata
);
  localparam int CPAD = DATA_W - FIELD_W;

  logic               rf_we, rf_pzero;
  logic [REG_AW-1:0]  rf_waddr, rf_paddr, rf_qaddr;
  logic [DATA_W-1:0]  rf_pdata, rf_qdata, rf_wdata, alu_y;
  logic [FIELD_W-1:0] imm;
  wsel_t              wsel;
  alu_op_t            alu_op;

  mcp_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .imem_data(imem_data),
    .rf_pzero (rf_pzero),
    .imem_rd  (imem_rd),
    .pc       (imem_addr),
    .imm      (imm),
    .d_rd     (dmem_rd),
    .d_wr     (dmem_wr),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr),
    .rf_paddr (rf_paddr),
    .rf_qaddr (rf_qaddr),
    .wsel     (wsel),
    .alu_op   (alu_op)
  );

  mcp_regfile #(.W(DATA_W), .AW(REG_AW)) u_rf (
    .clk  (clk),
    .we   (rf_we),
    .waddr(rf_waddr),
    .wdata(rf_wdata),
    .paddr(rf_paddr),
    .pdata(rf_pdata),
    .qaddr(rf_qaddr),
    .qdata(rf_qdata)
  );

  mcp_alu #(.W(DATA_W)) u_alu (
    .op(alu_op),
    .a (rf_pdata),
    .b (rf_qdata),
    .y (alu_y)
  );

  // zero detector on the p read port
  assign rf_pzero = ~|rf_pdata;

  always_comb begin
    case (wsel)
      WS_MEM:   rf_wdata = dmem_rdata;
      WS_CONST: rf_wdata = {{CPAD{1'b0}}, imm};
      default:  rf_wdata = alu_y;
    endcase
  end

  assign dmem_addr  = imm;
  assign dmem_wdata = rf_pdata;

  // R4: never read and write data memory in the same cycle
  a_r4_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !(dmem_rd && dmem_wr));

  // R3: a memory read always lands in the register file
  a_r3_load_path: assert property (@(posedge clk) disable iff (rst)
    dmem_rd |-> (rf_we && wsel == WS_MEM));

  // R4: a store never writes the register file
  a_r4_store_no_rf: assert property (@(posedge clk) disable iff (rst)
    dmem_wr |-> !rf_we);
endmodule

// File: tb/sim_mcp_core.sv
module sim_mcp_core;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imem_addr, imem_data, dmem_wdata, dmem_rdata;
  logic [7:0]  dmem_addr;
  logic        imem_rd, dmem_rd, dmem_wr;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcp_core u0 (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_rd(imem_rd), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
  );

  logic [15:0] imem [256];
  logic [15:0] dmem [256];
  assign imem_data  = imem[imem_addr[7:0]];
  assign dmem_rdata = dmem[dmem_addr];
  always @(posedge clk) if (dmem_wr) dmem[dmem_addr] <= dmem_wdata;

  int checks = 0;
  int errors = 0;

  // instruction-level reference model
  logic [15:0] m_rf [16];
  logic [15:0] m_dmem [256];
  logic [15:0] m_pc;
  logic        exp_rd, exp_wr;
  logic [7:0]  exp_addr;
  logic [15:0] exp_data;
  string       pc_tag;
  bit          mon_en = 1'b0;
  bit          first;
  int          since, cyc;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int a, input int b, input int c);
    return {op[3:0], a[3:0], b[3:0], c[3:0]};
  endfunction

  function automatic logic [15:0] enc8(input int op, input int a, input int k);
    return {op[3:0], a[3:0], k[7:0]};
  endfunction

  task automatic model_step();
    logic [15:0] ins;
    logic [3:0] op, ra, rb, rc;
    logic [7:0] k;
    ins = imem[m_pc[7:0]];
    op = ins[15:12]; ra = ins[11:8]; rb = ins[7:4]; rc = ins[3:0]; k = ins[7:0];
    exp_rd = 1'b0; exp_wr = 1'b0; exp_addr = k; exp_data = '0;
    pc_tag = "R11";
    m_pc = m_pc + 16'd1;
    case (op)
      4'h0: begin exp_rd = 1'b1; m_rf[ra] = m_dmem[k]; end
      4'h1: begin exp_wr = 1'b1; exp_data = m_rf[ra]; m_dmem[k] = m_rf[ra]; end
      4'h2: m_rf[ra] = m_rf[rb] + m_rf[rc];
      4'h3: m_rf[ra] = {8'h00, k};
      4'h4: m_rf[ra] = m_rf[rb] - m_rf[rc];
      4'h5: begin
        if (m_rf[ra] == 16'h0) begin
          m_pc = m_pc + {{8{k[7]}}, k} - 16'd1;
          pc_tag = "R8";
        end else pc_tag = "R9";
      end
      default: pc_tag = "R10";
    endcase
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      since++;
      cyc++;
      if (imem_rd) begin
        if (first) begin
          check(since == 2, "R1", "first fetch cycle", 16'(since), 16'd2);
          check(imem_addr == 16'h0, "R1", "first fetch address", imem_addr, 16'h0);
        end else begin
          check(cyc == 3, "R2", "fetch spacing", 16'(cyc), 16'd3);
          check(imem_addr == m_pc, pc_tag, "fetch address", imem_addr, m_pc);
        end
        m_pc = imem_addr;
        model_step();
        first = 1'b0;
        cyc = 0;
      end else if (first) begin
        if (since >= 2) check(1'b0, "R1", "no fetch after reset", 16'(since), 16'd2);
      end else if (cyc == 1) begin
        check(!dmem_rd && !dmem_wr, "R2", "decode memory strobe", {dmem_rd, dmem_wr}, 16'd0);
      end else if (cyc == 2) begin
        check(dmem_wr == exp_wr, "R4", "write strobe", 16'(dmem_wr), 16'(exp_wr));
        check(dmem_rd == exp_rd, "R3", "read strobe", 16'(dmem_rd), 16'(exp_rd));
        if (exp_wr) begin
          check(dmem_addr == exp_addr, "R4", "store address", 16'(dmem_addr), 16'(exp_addr));
          check(dmem_wdata == exp_data, "R4", "store data", dmem_wdata, exp_data);
        end
        if (exp_rd)
          check(dmem_addr == exp_addr, "R3", "load address", 16'(dmem_addr), 16'(exp_addr));
      end else if (cyc == 4) begin
        check(1'b0, "R2", "missing fetch", 16'(cyc), 16'd3);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      errors++;
      $display("FAIL R2 watchdog expired got %0d exp below %0d", wd, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // memories are loaded while reset is high, then reset is released
  task automatic start_run();
    @(posedge clk); #1;
    mon_en = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(!imem_rd && !dmem_rd && !dmem_wr, "R1", "strobes in reset",
          {imem_rd, dmem_rd, dmem_wr}, 16'd0);
    for (int i = 0; i < 256; i++) m_dmem[i] = dmem[i];
    for (int i = 0; i < 16; i++) m_rf[i] = 16'h0;
    m_pc = 16'h0; first = 1'b1; since = 0; cyc = 0;
    @(posedge clk); #1;
    rst = 1'b0;
    mon_en = 1'b1;
  endtask

  task automatic stop_run(input int n);
    repeat (n) @(posedge clk);
    #1;
    mon_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // directed program
    for (int i = 0; i < 256; i++) begin imem[i] = 16'h0; dmem[i] = 16'h0; end
    dmem[0]  = 16'hABCD;
    dmem[15] = 16'h1234;
    dmem[17] = 16'h5555;
    imem[0]  = enc8(0, 4, 0);        // load R4 <- D[0]
    imem[1]  = enc8(1, 4, 10);       // store D[10]
    imem[2]  = enc8(3, 4, 8'hF0);    // constant over a full-width value
    imem[3]  = enc8(1, 4, 11);
    imem[4]  = enc8(3, 1, 5);
    imem[5]  = enc8(3, 2, 7);
    imem[6]  = enc(2, 3, 1, 2);      // 5 + 7
    imem[7]  = enc8(1, 3, 12);
    imem[8]  = enc(4, 5, 1, 2);      // 5 - 7 wraps
    imem[9]  = enc8(1, 5, 13);
    imem[10] = 16'h7312;             // unused opcodes
    imem[11] = 16'hF3FF;
    imem[12] = enc8(1, 3, 14);
    imem[13] = enc8(3, 6, 0);
    imem[14] = enc8(5, 6, 3);        // taken forward to 17
    imem[15] = enc8(3, 7, 8'h11);
    imem[16] = enc8(1, 7, 15);
    imem[17] = enc8(5, 1, 5);        // not taken
    imem[18] = enc8(3, 7, 8'h22);
    imem[19] = enc8(1, 7, 16);
    imem[20] = enc8(3, 9, 3);
    imem[21] = enc8(3, 10, 1);
    imem[22] = enc(4, 9, 9, 10);     // count down
    imem[23] = enc8(5, 9, 2);        // exit to 25 at zero
    imem[24] = enc8(5, 6, 8'hFE);    // backward to 22
    imem[25] = enc8(1, 9, 17);
    imem[26] = enc8(5, 6, 0);        // self loop
    start_run();
    stop_run(150);
    check(dmem[10] == 16'hABCD, "R3", "loaded word stored", dmem[10], 16'hABCD);
    check(dmem[11] == 16'h00F0, "R6", "constant zero-extended", dmem[11], 16'h00F0);
    check(dmem[12] == 16'h000C, "R5", "add result", dmem[12], 16'h000C);
    check(dmem[13] == 16'hFFFE, "R7", "subtract wraps", dmem[13], 16'hFFFE);
    check(dmem[14] == 16'h000C, "R10", "register kept over no-ops", dmem[14], 16'h000C);
    check(dmem[15] == 16'h1234, "R8", "skipped store absent", dmem[15], 16'h1234);
    check(dmem[16] == 16'h0022, "R9", "fall-through store", dmem[16], 16'h0022);
    check(dmem[17] == 16'h0000, "R8", "backward loop exit", dmem[17], 16'h0000);

    // random programs
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 256; i++) dmem[i] = 16'($urandom);
      for (int i = 0; i < 16; i++)
        imem[i] = enc8(3, i, ($urandom % 3 == 0) ? 0 : int'($urandom % 256));
      for (int i = 16; i < 256; i++) begin
        int r, off;
        r = int'($urandom % 16);
        if (r < 3)       imem[i] = enc8(0, int'($urandom % 16), int'($urandom % 256));
        else if (r < 6)  imem[i] = enc8(1, int'($urandom % 16), int'($urandom % 256));
        else if (r < 8)  imem[i] = enc(2, int'($urandom % 16), int'($urandom % 16), int'($urandom % 16));
        else if (r < 9)  imem[i] = enc8(3, int'($urandom % 16), ($urandom % 2 == 0) ? 0 : int'($urandom % 256));
        else if (r < 11) imem[i] = enc(4, int'($urandom % 16), int'($urandom % 16), int'($urandom % 16));
        else if (r < 13) begin
          if ($urandom % 4 == 0) off = -(1 + int'($urandom % 6));
          else off = 1 + int'($urandom % 8);
          imem[i] = enc8(5, int'($urandom % 16), off);
        end else imem[i] = {4'(6 + $urandom % 10), 12'($urandom)};
      end
      start_run();
      stop_run(1500);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule